// File: doc/BRIEF.md
# Flash Program/Erase Status Tracker

This block keeps the status byte of a NOR-style flash write controller. Commands that some other block has already decoded arrive here one per clock, each tagged with whether the addressed block is locked and whether the programming supply is in range. A program or erase that is accepted drives a simulated busy period whose length comes from two programmable cycle counts. While that period runs, a suspend request can park the operation after a fixed latency. A resume request continues it.

The status byte can be read at any time. Error bits stay set until a clear-status command or a reset. An earlier lock violation that has not been cleared makes every later program or erase fail. A suspend that comes too late is dropped when the operation finishes inside the latency window. Three flags derived from the byte (busy, suspended, error) are also brought out as pins.

Top module: `pe_status_tracker`

## Requirements
- R1: After reset the status byte reads 8'h80, and busy, suspended and error are all 0.
- R2: cmd_code values are 1 = program, 2 = erase, 3 = suspend, 4 = resume and 5 = clear status. Other values do nothing. An accepted program or erase takes N = prog_cycles or erase_cycles, with 0 treated as 1. Bit 7 reads 0 for exactly N clocks after the accepting edge and then reads 1. A successful operation leaves bits 5 and 4 at 0.
- R3: Suspend latency L is SUSP_US microseconds at CLK_MHZ, which gives 500 cycles by default. If a suspend is accepted at work cycle t and more than L work cycles remain, the operation parks L cycles after the suspend edge. Bit 7 then reads 1, and bit 2 (for a program) or bit 6 (for an erase) reads 1.
- R4: A resume accepted while parked clears bits 2 and 6 and brings bit 7 back to 0 at the next clock. The operation then finishes after its remaining N - t - L work cycles.
- R5: If the running operation ends within L cycles of the suspend edge, it completes at its original time and no suspend bit is ever set.
- R6: A resume while nothing is parked, a second suspend, and a program or erase while busy or parked are all ignored.
- R7: A program or erase aimed at a locked block (blk_locked=1) does not start. Bit 7 stays 1 and bit 1 is set.
- R8: Bit 1 stays set until clear or reset. While it is set, a program or erase does not start and sets bit 4 (program) or bit 5 (erase).
- R9: A program or erase with vpp_ok=0 does not start. It sets bit 3 and bit 4 or bit 5. If several failure causes apply, the priority is: pending bit 1 first, then a locked block, then the supply.
- R10: Clear status zeroes bits 5, 4, 3 and 1 and leaves bits 7, 6 and 2 unchanged.
- R11: Bit 0 always reads 0. busy is the inverse of bit 7, suspended is bit 6 OR bit 2, and error is the OR of bits 5, 4, 3 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_code | input | 3 | Command code (see R2) |
| blk_locked | input | 1 | Target block of a program/erase is locked |
| vpp_ok | input | 1 | Programming supply is in range |
| prog_cycles | input | CNT_W | Work length of a program, in cycles |
| erase_cycles | input | CNT_W | Work length of an erase, in cycles |
| status | output | 8 | Status byte |
| busy | output | 1 | Operation in progress |
| suspended | output | 1 | An operation is parked |
| error | output | 1 | Any sticky error bit is set |

## Verification
The assertions assume at most one command per cycle. They also assume that blk_locked, vpp_ok and the cycle counts matter only on the cycle a program or erase is presented. The bench changes inputs only at the falling edge and raises cmd_valid for one cycle per command. It loads the cycle counts before the command that uses them. It draws suspend points both inside and beyond the latency window, so both the parking path and the completion-wins path are reached.

// File: rtl/fst_pkg.sv
package fst_pkg;
  localparam logic [2:0] CMD_PROG   = 3'd1;
  localparam logic [2:0] CMD_ERASE  = 3'd2;
  localparam logic [2:0] CMD_SUSP   = 3'd3;
  localparam logic [2:0] CMD_RESUME = 3'd4;
  localparam logic [2:0] CMD_CLEAR  = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SPEND, ST_PARK} fst_state_e;
  typedef enum logic {OP_PROG, OP_ERASE} fst_op_e;

  // suspend latency in clock cycles for a given clock rate and time window
  function automatic int susp_latency(input int mhz, input int us);
    int v;
    v = mhz * us;
    return (v < 1) ? 1 : v;
  endfunction
endpackage

// File: rtl/fst_cmd_gate.sv
module fst_cmd_gate
  import fst_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  fst_state_e state,
  input  logic       lock_pending,
  input  logic       blk_locked,
  input  logic       vpp_ok,
  output logic       ev_start,
  output fst_op_e    ev_kind,
  output logic       ev_fail_pending,
  output logic       ev_lock_abort,
  output logic       ev_vpp_abort,
  output logic       ev_susp_req,
  output logic       ev_resume,
  output logic       ev_clear
);
  logic is_write, write_idle;

  always_comb begin
    is_write   = cmd_valid && (cmd_code == CMD_PROG || cmd_code == CMD_ERASE);
    write_idle = is_write && (state == ST_IDLE);
    ev_kind    = (cmd_code == CMD_ERASE) ? OP_ERASE : OP_PROG;
    ev_fail_pending = write_idle && lock_pending;
    ev_lock_abort   = write_idle && !lock_pending && blk_locked;
    ev_vpp_abort    = write_idle && !lock_pending && !blk_locked && !vpp_ok;
    ev_start        = write_idle && !lock_pending && !blk_locked && vpp_ok;
    ev_susp_req     = cmd_valid && cmd_code == CMD_SUSP && state == ST_RUN;
    ev_resume       = cmd_valid && cmd_code == CMD_RESUME && state == ST_PARK;
    ev_clear        = cmd_valid && cmd_code == CMD_CLEAR;
  end
endmodule

// File: rtl/fst_op_timer.sv
module fst_op_timer #(
  parameter int CNT_W = 16,
  parameter int LAT   = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  input  logic             run,
  input  logic             susp_arm,
  input  logic             lat_active,
  output logic             op_done,
  output logic             susp_hit
);
  localparam int LAT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0] rem;
  logic [LAT_W-1:0] lat;

  // zero-length requests still take one work cycle
  function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] n);
    return (n == '0) ? CNT_W'(1) : n;
  endfunction

  assign op_done  = run && (rem == CNT_W'(1));
  assign susp_hit = lat_active && (lat == LAT_W'(1)) && !op_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem <= '0;
      lat <= '0;
    end else begin
      if (load)     rem <= eff_len(load_len);
      else if (run) rem <= rem - CNT_W'(1);
      if (susp_arm)                       lat <= LAT_W'(LAT);
      else if (lat_active && lat != '0)   lat <= lat - LAT_W'(1);
    end
  end

  AST_REM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rem != '0)); // R2
endmodule

// File: rtl/fst_err_flags.sv
module fst_err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_prog,
  input  logic set_erase,
  input  logic set_vpp,
  input  logic set_lock,
  input  logic clear,
  output logic prog_q,
  output logic erase_q,
  output logic vpp_q,
  output logic lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      vpp_q   <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      if (set_prog)  prog_q  <= 1'b1;
      if (set_erase) erase_q <= 1'b1;
      if (set_vpp)   vpp_q   <= 1'b1;
      if (set_lock)  lock_q  <= 1'b1;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !clear) |=> lock_q); // R8
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !(prog_q || erase_q || vpp_q || lock_q)); // R10
endmodule

// File: rtl/pe_status_tracker.sv
module pe_status_tracker
  import fst_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CLK_MHZ = 100,
  parameter int SUSP_US = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic             blk_locked,
  input  logic             vpp_ok,
  input  logic [CNT_W-1:0] prog_cycles,
  input  logic [CNT_W-1:0] erase_cycles,
  output logic [7:0]       status,
  output logic             busy,
  output logic             suspended,
  output logic             error
);
  localparam int LAT = susp_latency(CLK_MHZ, SUSP_US);

  fst_state_e state;
  fst_op_e    kind;
  logic ev_start, ev_fail_pending, ev_lock_abort, ev_vpp_abort;
  logic ev_susp_req, ev_resume, ev_clear;
  fst_op_e ev_kind;
  logic op_done, susp_hit;
  logic prog_q, erase_q, vpp_q, lock_q;
  logic set_fail;

  fst_cmd_gate u_gate (
    .cmd_valid, .cmd_code, .state, .lock_pending(lock_q), .blk_locked, .vpp_ok,
    .ev_start, .ev_kind, .ev_fail_pending, .ev_lock_abort, .ev_vpp_abort,
    .ev_susp_req, .ev_resume, .ev_clear
  );

  fst_op_timer #(.CNT_W(CNT_W), .LAT(LAT)) u_timer (
    .clk, .rst_n,
    .load(ev_start),
    .load_len((ev_kind == OP_ERASE) ? erase_cycles : prog_cycles),
    .run(state == ST_RUN || state == ST_SPEND),
    .susp_arm(ev_susp_req && !op_done),
    .lat_active(state == ST_SPEND),
    .op_done, .susp_hit
  );

  assign set_fail = ev_fail_pending || ev_vpp_abort;

  fst_err_flags u_err (
    .clk, .rst_n,
    .set_prog(set_fail && ev_kind == OP_PROG),
    .set_erase(set_fail && ev_kind == OP_ERASE),
    .set_vpp(ev_vpp_abort),
    .set_lock(ev_lock_abort),
    .clear(ev_clear),
    .prog_q, .erase_q, .vpp_q, .lock_q
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      kind  <= OP_PROG;
    end else begin
      unique case (state)
        ST_IDLE:  if (ev_start) begin
                    state <= ST_RUN;
                    kind  <= ev_kind;
                  end
        ST_RUN:   if (op_done)          state <= ST_IDLE;
                  else if (ev_susp_req) state <= ST_SPEND;
        ST_SPEND: if (op_done)          state <= ST_IDLE;
                  else if (susp_hit)    state <= ST_PARK;
        ST_PARK:  if (ev_resume)        state <= ST_RUN;
        default:                        state <= ST_IDLE;
      endcase
    end
  end

  logic parked;
  assign parked = (state == ST_PARK);
  assign status = {state == ST_IDLE || parked,
                   parked && kind == OP_ERASE,
                   erase_q, prog_q, vpp_q,
                   parked && kind == OP_PROG,
                   lock_q, 1'b0};
  assign busy      = !status[7];
  assign suspended = status[6] | status[2];
  assign error     = status[5] | status[4] | status[3] | status[1];

  AST_RESUME_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resume |=> (busy && !suspended)); // R4
  AST_LATE_SUSP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SPEND && op_done) |=> (!busy && !suspended)); // R5
  AST_NO_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fail_pending || ev_lock_abort) |=> !busy); // R8
  AST_CLEAR_KEEPS_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clear && parked && !ev_resume) |=> (suspended && !busy)); // R10
  AST_PARK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(state == ST_SPEND && susp_hit)); // R3
endmodule

// File: tb/pe_status_tracker_bench.sv
module pe_status_tracker_bench;
  localparam int L = 100 * 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic blk_locked = 1'b0;
  logic vpp_ok = 1'b1;
  logic [15:0] prog_cycles = 16'd10;
  logic [15:0] erase_cycles = 16'd10;
  logic [7:0] status;
  logic busy, suspended, error;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pe_status_tracker u_pe_status_tracker (
    .clk, .rst_n, .cmd_valid, .cmd_code, .blk_locked, .vpp_ok,
    .prog_cycles, .erase_cycles, .status, .busy, .suspended, .error
  );

  function automatic logic [7:0] park_byte(input int kind);
    return (kind == 2) ? 8'hC0 : 8'h84;
  endfunction
  function automatic logic [7:0] err_bit(input int kind);
    return (kind == 2) ? 8'h20 : 8'h10;
  endfunction
  function automatic bit will_park(input int n, input int t);
    return (t < n) && (n - t > L);
  endfunction

  task automatic cyc(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic send(input int code);
    cmd_valid = 1'b1;
    cmd_code  = 3'(code);
    cyc(1);
    cmd_valid = 1'b0;
    cmd_code  = 3'd0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // kind 1 = program, 2 = erase; sus_t 0 = no suspend
  task automatic do_op(input int kind, input int n_raw, input int sus_t, input int gap);
    int n;
    n = (n_raw == 0) ? 1 : n_raw;
    if (kind == 2) erase_cycles = 16'(n_raw); else prog_cycles = 16'(n_raw);
    send(kind);
    chk(status, 8'h00, "R2 busy after start");
    if (sus_t > 0 && sus_t < n) begin
      cyc(sus_t - 1);
      send(3);
      if (will_park(n, sus_t)) begin
        cyc(L - 1);
        chk(status, 8'h00, "R3 busy within latency");
        cyc(1);
        chk(status, park_byte(kind), "R3 parked byte");
        chk({7'd0, suspended}, 8'h01, "R11 suspended pin");
        send(3);
        chk(status, park_byte(kind), "R6 second suspend ignored");
        send(kind);
        chk(status, park_byte(kind), "R6 write while parked ignored");
        cyc(gap);
        send(4);
        chk(status, 8'h00, "R4 resume busy");
        cyc(n - sus_t - L - 1);
        chk(status, 8'h00, "R4 busy before remaining ends");
        cyc(1);
        chk(status, 8'h80, "R4 ready after remaining work");
      end else begin
        cyc(n - sus_t - 1);
        chk(status, 8'h00, "R5 busy, no suspend bit");
        cyc(1);
        chk(status, 8'h80, "R5 completes at original time");
      end
    end else begin
      cyc(n - 1);
      chk(status, 8'h00, "R2 busy last cycle");
      cyc(1);
      chk(status, 8'h80, "R2 ready after N");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(status, 8'h80, "R1 reset byte");
    chk({5'd0, busy, suspended, error}, 8'h00, "R1 reset pins");
    chk({7'd0, status[0]}, 8'h00, "R11 reserved bit");

    do_op(1, 20, 0, 0);
    do_op(2, 0, 0, 0);
    do_op(1, 2000, 100, 5);
    do_op(2, 1500, 400, 1);
    do_op(1, 700, 300, 1);
    do_op(2, 600, 100, 1);

    send(4);
    chk(status, 8'h80, "R6 resume while idle ignored");
    send(6);
    chk(status, 8'h80, "R2 unknown code ignored");

    // resume while running is ignored, timing unchanged
    prog_cycles = 16'd30;
    send(1);
    send(4);
    cyc(28);
    chk(status, 8'h00, "R6 resume while running ignored");
    cyc(1);
    chk(status, 8'h80, "R6 run ends on time");

    blk_locked = 1'b1;
    send(1);
    chk(status, 8'h82, "R7 locked block abort");
    chk({6'd0, busy, error}, 8'h01, "R11 error pin");
    blk_locked = 1'b0;
    send(2);
    chk(status, 8'hA2, "R8 erase fails on pending lock");
    send(1);
    chk(status, 8'hB2, "R8 program fails on pending lock");
    send(5);
    chk(status, 8'h80, "R10 clear");

    vpp_ok = 1'b0;
    send(1);
    chk(status, 8'h98, "R9 supply fault");
    blk_locked = 1'b1;
    send(2);
    chk(status, 8'h9A, "R9 lock wins over supply");
    send(5);
    blk_locked = 1'b0;
    send(1);
    chk(status, 8'h98, "R9 supply fault again");
    vpp_ok = 1'b1;

    // clear while an erase is parked keeps bits 7 and 6
    erase_cycles = 16'(L + 50);
    send(2);
    send(3);
    cyc(L);
    chk(status, 8'hD8, "R10 parked with errors");
    send(5);
    chk(status, 8'hC0, "R10 clear keeps park bits");
    send(4);
    cyc(48);
    chk(status, 8'h00, "R4 busy after resume");
    cyc(1);
    chk(status, 8'h80, "R4 done");

    for (int it = 0; it < 40; it++) begin
      int kind, n, t, sel;
      kind = int'($urandom_range(2, 1));
      sel  = int'($urandom_range(9, 0));
      if (sel == 0) begin
        blk_locked = 1'b1;
        send(kind);
        chk(status, 8'h82, "R7 random locked");
        blk_locked = 1'b0;
        send(5);
        chk(status, 8'h80, "R10 random clear");
      end else if (sel == 1) begin
        vpp_ok = 1'b0;
        send(kind);
        chk(status, 8'h88 | err_bit(kind), "R9 random supply");
        vpp_ok = 1'b1;
        send(5);
        chk(status, 8'h80, "R10 random clear");
      end else begin
        n = int'($urandom_range(1500, 1));
        t = (sel < 6) ? int'($urandom_range(n, 1)) : 0;
        do_op(kind, n, t, int'($urandom_range(20, 1)));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule